// File: doc/BRIEF.md
# Bit-Serial Self-Steering Sorting Network

This block sorts a group of N unsigned words that arrive one bit at a time. Each word travels on its own one-bit lane, most significant bit first. A start marker flags the cycle that carries the leading bit of every lane in the group. Inside the block, compare-exchange cells are arranged as a bitonic network. Each cell is a one-bit two-in/two-out switch. It sends its two bits straight through until the two lanes disagree. At that bit it locks a crossing decision, so the smaller word leaves on its lower-index output, and it keeps that decision until the next start marker. Once a cell has seen a disagreement, no later bit of the word can change its routing, so no cell ever needs a full-width comparator.

The network has log2(N) merge phases, and phase p holds p cell columns. This gives S = L(L+1)/2 register stages in total, where L = log2(N). The start marker is registered beside the data at every stage, so each column clears its decisions on exactly the bit that opens a new word. Groups may follow each other with no gap between them.

The input and output sides are valid/ready streams. A beat moves through the network only while the output side can take a beat. When the output holds valid data and the consumer deasserts ready, the whole pipeline freezes, and `in_ready` drops in that same cycle. An input cycle without valid inserts a bubble. The bubble travels along the network and changes no cell's decision.

Top module: `bsort_net`

## Requirements
- R1: When a group's W output bits have been collected, output lane i holds the i-th smallest of the N input words (lane 0 smallest), compared as unsigned numbers sent MSB first.
- R2: On the first bit position where its two inputs differ, an ascending cell sends the 0 bit to its lower-index output and the 1 bit to its higher-index output.
- R3: After a cell has locked its routing, that routing stays unchanged for every remaining bit of the word and is released only by the next start-marked beat.
- R4: Words with equal values, including a group where every word is equal, appear at the outputs unchanged, with the multiset of output words equal to the multiset of input words.
- R5: With no back-pressure, the start-marked output beat of a group appears S = L(L+1)/2 clocks after its start-marked input beat is accepted (6 for N = 8).
- R6: A new group may begin in the cycle right after the last bit of the previous group, and both groups still sort correctly.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` and `out_first` hold their values into the next cycle.
- R8: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R9: `out_first` is 1 only together with `out_valid`, and it marks the MSB beat of each sorted output group.
- R10: Input cycles with `in_valid` at 0 placed between the bits of a group do not change the sorted result of that group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Network can accept a beat |
| in_first | input | 1 | Beat carries the MSB of a new group |
| in_data | input | N | One bit per input lane |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_first | output | 1 | Beat carries the MSB of a sorted group |
| out_data | output | N | One bit per lane, lane 0 smallest |

## Verification
The network is driven with groups that are already sorted, reversed, all equal, full of duplicates, at the extremes (zero and all ones), different only in their last bit, and random. Already-sorted and reversed groups show that cells cross exactly when they should. Groups that differ only in the last bit show that an undecided cell stays transparent until the final bit. Equal and duplicate groups show that ties never lose or duplicate a word. The runs are repeated back to back, with input bubbles, and with a randomly stalling consumer, which tells correct decision latching apart from decisions corrupted by gaps or freezes.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

  // Number of compare-exchange columns in a bitonic network of 2**lg lanes
  function automatic int stage_count(input int lg);
    return (lg * (lg + 1)) / 2;
  endfunction

  // Column index of sub-step q inside merge phase p (p counts from 1)
  function automatic int column_index(input int p, input int q);
    return ((p * (p - 1)) / 2) + q;
  endfunction

endpackage

// File: rtl/bsort_cell.sv
module bsort_cell #(
  parameter bit DESC = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vld_in,
  input  logic first_in,
  input  logic a,
  input  logic b,
  output logic lo,
  output logic hi
);

  logic decided;
  logic swap_q;
  logic diff;
  logic raw_swap;
  logic sw;

  assign diff     = a ^ b;
  assign raw_swap = DESC ? (b & ~a) : (a & ~b);
  assign sw       = (decided && !first_in) ? swap_q : raw_swap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decided <= 1'b0;
      swap_q  <= 1'b0;
      lo      <= 1'b0;
      hi      <= 1'b0;
    end else if (en) begin
      lo <= sw ? b : a;
      hi <= sw ? a : b;
      if (vld_in) begin
        if (first_in || !decided) begin
          decided <= diff;
          swap_q  <= raw_swap;
        end
      end
    end
  end

  // R3: a locked routing is kept until a start-marked beat is taken
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && !(en && vld_in && first_in)) |=> (decided && $stable(swap_q)));

  // R2: first differing bit sends the 0 to the low output (ascending cell)
  p_first_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld_in && first_in && diff) |=> (lo == (DESC ? 1'b1 : 1'b0)));

  // R4: equal bits at the word start pass straight through
  p_equal_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld_in && first_in && !diff) |=> (lo == $past(a) && hi == $past(b)));

endmodule

// File: rtl/bsort_stage.sv
module bsort_stage #(
  parameter int N = 8,
  parameter int K = 2,
  parameter int J = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vld_i,
  input  logic         first_i,
  input  logic [N-1:0] data_i,
  output logic         vld_o,
  output logic         first_o,
  output logic [N-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      first_o <= 1'b0;
    end else if (en) begin
      vld_o   <= vld_i;
      first_o <= vld_i & first_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    if ((i & J) == 0) begin : g_cell
      bsort_cell #(
        .DESC(((i & K) != 0))
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .vld_in  (vld_i),
        .first_in(first_i),
        .a       (data_i[i]),
        .b       (data_i[i+J]),
        .lo      (data_o[i]),
        .hi      (data_o[i+J])
      );
    end
  end

endmodule

// File: rtl/bsort_net.sv
module bsort_net
  import bsort_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_first,
  input  logic [N-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_first,
  output logic [N-1:0] out_data
);

  localparam int L = $clog2(N);
  localparam int S = stage_count(L);

  logic [N-1:0] lane_bus [0:S];
  logic         vld_bus  [0:S];
  logic         fst_bus  [0:S];
  logic         advance;

  assign advance    = !vld_bus[S] || out_ready;
  assign in_ready   = advance;
  assign lane_bus[0] = in_data;
  assign vld_bus[0]  = in_valid;
  assign fst_bus[0]  = in_first;

  for (genvar p = 1; p <= L; p++) begin : g_phase
    for (genvar q = 0; q < p; q++) begin : g_step
      localparam int COL = column_index(p, q);
      bsort_stage #(
        .N(N),
        .K(1 << p),
        .J(1 << (p - 1 - q))
      ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (advance),
        .vld_i  (vld_bus[COL]),
        .first_i(fst_bus[COL]),
        .data_i (lane_bus[COL]),
        .vld_o  (vld_bus[COL+1]),
        .first_o(fst_bus[COL+1]),
        .data_o (lane_bus[COL+1])
      );
    end
  end

  assign out_valid = vld_bus[S];
  assign out_first = fst_bus[S];
  assign out_data  = lane_bus[S];

  // R7: a stalled output beat is held
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)));

  // R9: the start marker never appears without valid
  p_first_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

endmodule

// File: tb/bsort_net_tb.sv
module bsort_net_tb;
  localparam int N = 8;
  localparam int W = 8;
  localparam int L = $clog2(N);
  localparam int S = (L * (L + 1)) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_first = 1'b0;
  logic [N-1:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_first;
  logic [N-1:0] out_data;

  always #2 clk = ~clk;

  bsort_net #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first), .out_data(out_data)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit rnd_ready = 1'b0;
  bit chk_lat = 1'b1;
  bit done = 1'b0;
  int gap = 0;

  logic [N-1:0][W-1:0] exp_q [$];
  string tag_q [$];
  int    t_q [$];
  bit    lat_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(posedge clk);
    #1 out_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_group(input logic [N-1:0][W-1:0] w, input string tag);
    logic [N-1:0][W-1:0] s;
    s = w;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (s[j] > s[j+1]) begin
          logic [W-1:0] t;
          t = s[j]; s[j] = s[j+1]; s[j+1] = t;
        end
    exp_q.push_back(s);
    tag_q.push_back(tag);
    lat_q.push_back(chk_lat);
    for (int b = W - 1; b >= 0; b--) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (b == W - 1);
      for (int i = 0; i < N; i++) in_data[i] = w[i][b];
      while (!in_ready) @(negedge clk);
      if (b == W - 1) t_q.push_back(cyc);
      if (gap > 0 && b > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data = N'($urandom);
        in_first = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  // back-to-back variant: no idle beat between groups (R6)
  task automatic send_b2b(input logic [N-1:0][W-1:0] w1, input logic [N-1:0][W-1:0] w2);
    logic [N-1:0][W-1:0] g [2];
    g[0] = w1; g[1] = w2;
    for (int k = 0; k < 2; k++) begin
      logic [N-1:0][W-1:0] s;
      s = g[k];
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N - 1 - i; j++)
          if (s[j] > s[j+1]) begin
            logic [W-1:0] t;
            t = s[j]; s[j] = s[j+1]; s[j+1] = t;
          end
      exp_q.push_back(s);
      tag_q.push_back("R6 back-to-back");
      lat_q.push_back(chk_lat);
    end
    for (int k = 0; k < 2; k++)
      for (int b = W - 1; b >= 0; b--) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_first = (b == W - 1);
        for (int i = 0; i < N; i++) in_data[i] = g[k][i][b];
        while (!in_ready) @(negedge clk);
        if (b == W - 1) t_q.push_back(cyc);
      end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  // scoreboard monitor
  logic [W-1:0] got [N];
  int bitcnt = 0;
  bit held = 1'b0;
  logic [N-1:0] held_data;
  logic held_first;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (held) begin
        check(out_valid && out_data == held_data && out_first == held_first,
              "R7", "stalled beat not held", {63'b0, out_valid}, 64'd1);
      end
      held = out_valid && !out_ready;
      if (held) begin
        held_data = out_data;
        held_first = out_first;
        check(!in_ready, "R7", "in_ready during stall", {63'b0, in_ready}, 64'd0);
      end
      if (out_first && !out_valid)
        check(1'b0, "R9", "first without valid", 64'd1, 64'd0);
      if (out_valid && out_ready) begin
        if (out_first) begin
          int t;
          bit l;
          check(bitcnt == 0 || bitcnt == W, "R9", "marker position", bitcnt, W);
          bitcnt = 0;
          t = t_q.pop_front();
          l = lat_q[0];
          if (l) check(cyc - t == S, "R5", "latency", cyc - t, S);
        end
        for (int i = 0; i < N; i++) got[i] = {got[i][W-2:0], out_data[i]};
        bitcnt++;
        if (bitcnt == W) begin
          logic [N-1:0][W-1:0] e;
          string tg;
          bit ok;
          logic [N-1:0][W-1:0] g;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          void'(lat_q.pop_front());
          for (int i = 0; i < N; i++) g[i] = got[i];
          ok = (g == e);
          check(ok, tg, "sorted group", g, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [N-1:0][W-1:0] rnd_group();
    logic [N-1:0][W-1:0] r;
    for (int i = 0; i < N; i++) r[i] = W'($urandom);
    return r;
  endfunction

  function automatic logic [N-1:0][W-1:0] dup_group();
    logic [N-1:0][W-1:0] r;
    for (int i = 0; i < N; i++) r[i] = W'($urandom % 3) * W'(8'h21);
    return r;
  endfunction

  initial begin
    logic [N-1:0][W-1:0] g;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", {63'b0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", {63'b0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", {63'b0, out_valid}, 64'd0);

    for (int i = 0; i < N; i++) g[i] = W'(i * 3);
    send_group(g, "R1 presorted");
    for (int i = 0; i < N; i++) g[i] = W'(200 - i * 7);
    send_group(g, "R1 R2 reversed");
    for (int i = 0; i < N; i++) g[i] = 8'h5A;
    send_group(g, "R4 all equal");
    send_group(dup_group(), "R4 duplicates");
    for (int i = 0; i < N; i++) g[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
    send_group(g, "R1 extremes");
    for (int i = 0; i < N; i++) g[i] = {7'h3C, 1'(~i[0])};
    send_group(g, "R3 lsb only");
    send_b2b(rnd_group(), dup_group());
    send_b2b(rnd_group(), rnd_group());
    for (int k = 0; k < 4; k++) send_group(rnd_group(), "R1 random");

    gap = 2;
    for (int k = 0; k < 4; k++) send_group(rnd_group(), "R10 bubbles");
    send_group(dup_group(), "R10 R4 bubbles");
    gap = 0;

    repeat (S + 2) @(negedge clk);
    chk_lat = 1'b0;
    rnd_ready = 1'b1;
    for (int k = 0; k < 5; k++) send_group(rnd_group(), "R7 stalled");
    send_b2b(rnd_group(), dup_group());
    gap = 1;
    send_group(rnd_group(), "R7 R10 stall bubbles");
    gap = 0;

    while (exp_q.size() != 0) @(negedge clk);
    rnd_ready = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule